// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block keeps, for each hardware thread of an instruction fetch stage, a small state machine that records what fetch may do for that thread in the current cycle. Downstream stages send it block and unblock pulses, and it keeps one sticky stall bit per stage. Commit and decode send squash requests that carry a redirect address, and commit also sends a flag while it is still unwinding the reorder buffer. The instruction cache side reports when a miss is issued and when the line comes back, and the fetch datapath reports each fetch attempt.

All of these inputs can arrive in the same cycle, so the controller settles them with a fixed priority. The result for each thread is a registered status, a registered fetch address pair (current and sequential next), and a stall flag. A single stage-active output shows whether any thread can make progress, which lets the surrounding pipeline clock-gate or skip the stage when nothing is live. The number of threads, the address width, the instruction size and the reset address are parameters.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After synchronous reset, every thread reads status Running (code 0), no stall bit is set, the fetch address equals RESET_PC and the next address equals RESET_PC + INST_BYTES. Status codes are Running 0, Blocked 1, Squashing 2, WaitResponse 3 and LineReady 4, each 4 bits wide at status_o[t*4 +: 4].
- R2: Thread t owns four sticky stall bits at stall_set_i/stall_clr_i index t*4+s, with s = 0 for decode, 1 for rename, 2 for execute and 3 for commit. A set pulse raises the bit and a clear pulse lowers it. stalled_o[t] is the OR of the thread's bits, updated one cycle after the pulse. A clear pulse for a bit that is not set, or one given together with its set pulse, is illegal.
- R3: A commit squash takes priority over every other input. One cycle later the status is Squashing, the fetch address is the commit target, and the next address is the target plus INST_BYTES.
- R4: Unless a commit squash is present, while rob_unwind_i[t] is high the status is Squashing and the fetch address does not change, even if a decode squash is also present.
- R5: A decode squash sets Squashing and loads the decode target (next = target + INST_BYTES) only when the thread is not already in Squashing. When the thread is already in Squashing, the decode squash leaves the address unchanged.
- R6: When no squash applies and the thread's stall bits (with this cycle's pulses applied) are non-zero or ctx_switch_i is high, the status becomes Blocked. The exception is WaitResponse, which is kept.
- R7: A thread in Blocked or Squashing with no squash, no unwind and no stall returns to Running in the next cycle.
- R8: A miss issue moves a thread in Running or LineReady to WaitResponse when no higher-priority input applies.
- R9: A line return moves a thread in WaitResponse to Blocked if it is stalled, and to LineReady otherwise. A line return seen in any other status has no effect.
- R10: A fetch attempt moves a thread in LineReady to Running.
- R11: stage_active_o is high exactly when at least one thread is in Running, Squashing or LineReady.
- R12: Inputs for one thread never change another thread's status, address or stall flag. ctx_switch_i is the only input shared by all threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_set_i | input | NT*4 | Per-thread, per-stage block pulses |
| stall_clr_i | input | NT*4 | Per-thread, per-stage unblock pulses |
| ctx_switch_i | input | 1 | Context switch in progress, stalls all threads |
| cmt_squash_i | input | NT | Squash request from commit |
| cmt_target_i | input | NT*AW | Commit redirect address per thread |
| rob_unwind_i | input | NT | Reorder buffer still squashing |
| dec_squash_i | input | NT | Squash request from decode |
| dec_target_i | input | NT*AW | Decode redirect address per thread |
| miss_issue_i | input | NT | Cache miss request issued for the thread |
| line_ret_i | input | NT | Cache line returned for the thread |
| fetch_try_i | input | NT | Fetch attempted for the thread this cycle |
| status_o | output | NT*4 | Registered status per thread |
| pc_o | output | NT*AW | Current fetch address per thread |
| npc_o | output | NT*AW | Sequential next address per thread |
| stalled_o | output | NT | OR of each thread's stall bits |
| stage_active_o | output | 1 | Some thread is live |

## Verification
The priority chain is driven with deliberately conflicting input mixes. A commit squash arrives together with a decode squash and a new block, which shows whether commit truly wins and whether the stall still takes effect one cycle later. An unwind arrives together with a decode squash, which shows whether unwind masks decode. Two back-to-back decode squashes show the suppression while already squashing. The cache side is run through a miss, then a stall, then a line return, and again without the stall, which separates the Blocked and LineReady outcomes. Stray line returns are given in Running and after a squash to show they are dropped. Overlapping stalls from two stages and a shared context switch with both threads parked separate the per-bit stickiness from the per-thread independence and from the stage-active reduction.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int STAGE_CNT = 4;
    localparam int ST_W      = 4;

    typedef enum logic [ST_W-1:0] {
        ST_RUN        = 4'd0,
        ST_BLOCKED    = 4'd1,
        ST_SQUASH     = 4'd2,
        ST_WAIT_RESP  = 4'd3,
        ST_LINE_READY = 4'd4
    } fetch_st_e;

    typedef struct packed {
        logic cmt_sq;
        logic rob_sq;
        logic dec_sq;
        logic line_ret;
        logic miss_issue;
        logic fetch_try;
    } thr_ev_t;

    function automatic logic is_live(fetch_st_e s);
        return (s == ST_RUN) || (s == ST_SQUASH) || (s == ST_LINE_READY);
    endfunction

endpackage

// File: rtl/fsc_stall_bank.sv
module fsc_stall_bank #(
    parameter int STAGES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAGES-1:0] set_i,
    input  logic [STAGES-1:0] clr_i,
    output logic [STAGES-1:0] bits_q,
    output logic              any_next_o,
    output logic              any_q_o
);
    logic [STAGES-1:0] bits_n;

    // set first, then clear: matches the per-cycle update order
    always_comb begin
        bits_n = (bits_q | set_i) & ~clr_i;
    end

    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= bits_n;
    end

    assign any_next_o = |bits_n;
    assign any_q_o    = |bits_q;
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          INST_BYTES = 4,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  thr_ev_t       ev_i,
    input  logic          stalled_i,
    input  logic [AW-1:0] cmt_tgt_i,
    input  logic [AW-1:0] dec_tgt_i,
    output fetch_st_e     st_q,
    output logic [AW-1:0] pc_q,
    output logic [AW-1:0] npc_q
);
    localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

    fetch_st_e     st_n;
    logic          redirect;
    logic [AW-1:0] tgt;

    always_comb begin
        st_n     = st_q;
        redirect = 1'b0;
        tgt      = cmt_tgt_i;
        if (ev_i.cmt_sq) begin
            st_n     = ST_SQUASH;
            redirect = 1'b1;
        end else if (ev_i.rob_sq) begin
            st_n = ST_SQUASH;
        end else if (ev_i.dec_sq && st_q != ST_SQUASH) begin
            st_n     = ST_SQUASH;
            redirect = 1'b1;
            tgt      = dec_tgt_i;
        end else if (stalled_i && st_q != ST_WAIT_RESP) begin
            st_n = ST_BLOCKED;
        end else if (st_q == ST_BLOCKED || st_q == ST_SQUASH) begin
            st_n = ST_RUN;
        end else begin
            unique case (st_q)
                ST_WAIT_RESP: begin
                    if (ev_i.line_ret)
                        st_n = stalled_i ? ST_BLOCKED : ST_LINE_READY;
                end
                ST_RUN: begin
                    if (ev_i.miss_issue) st_n = ST_WAIT_RESP;
                end
                ST_LINE_READY: begin
                    if (ev_i.miss_issue)     st_n = ST_WAIT_RESP;
                    else if (ev_i.fetch_try) st_n = ST_RUN;
                end
                default: st_n = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            pc_q  <= RESET_PC;
            npc_q <= RESET_PC + STEP;
        end else begin
            st_q <= st_n;
            if (redirect) begin
                pc_q  <= tgt;
                npc_q <= tgt + STEP;
            end
        end
    end
endmodule

// File: rtl/fsc_activity.sv
module fsc_activity
    import fsc_pkg::*;
#(
    parameter int NT = 2
) (
    input  logic [NT*ST_W-1:0] st_flat_i,
    output logic               active_o
);
    always_comb begin
        active_o = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (is_live(fetch_st_e'(st_flat_i[i*ST_W +: ST_W]))) active_o = 1'b1;
        end
    end
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int            NT         = 2,
    parameter int            AW         = 32,
    parameter int            INST_BYTES = 4,
    parameter logic [AW-1:0] RESET_PC   = 32'h0000_1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NT*4-1:0]    stall_set_i,
    input  logic [NT*4-1:0]    stall_clr_i,
    input  logic               ctx_switch_i,
    input  logic [NT-1:0]      cmt_squash_i,
    input  logic [NT*AW-1:0]   cmt_target_i,
    input  logic [NT-1:0]      rob_unwind_i,
    input  logic [NT-1:0]      dec_squash_i,
    input  logic [NT*AW-1:0]   dec_target_i,
    input  logic [NT-1:0]      miss_issue_i,
    input  logic [NT-1:0]      line_ret_i,
    input  logic [NT-1:0]      fetch_try_i,
    output logic [NT*4-1:0]    status_o,
    output logic [NT*AW-1:0]   pc_o,
    output logic [NT*AW-1:0]   npc_o,
    output logic [NT-1:0]      stalled_o,
    output logic               stage_active_o
);
    logic [NT*STAGE_CNT-1:0] stall_flat;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic      any_next;
        thr_ev_t   ev;
        fetch_st_e st;

        fsc_stall_bank #(.STAGES(STAGE_CNT)) u_stall (
            .clk        (clk),
            .rst        (rst),
            .set_i      (stall_set_i[t*STAGE_CNT +: STAGE_CNT]),
            .clr_i      (stall_clr_i[t*STAGE_CNT +: STAGE_CNT]),
            .bits_q     (stall_flat[t*STAGE_CNT +: STAGE_CNT]),
            .any_next_o (any_next),
            .any_q_o    (stalled_o[t])
        );

        always_comb begin
            ev.cmt_sq     = cmt_squash_i[t];
            ev.rob_sq     = rob_unwind_i[t];
            ev.dec_sq     = dec_squash_i[t];
            ev.line_ret   = line_ret_i[t];
            ev.miss_issue = miss_issue_i[t];
            ev.fetch_try  = fetch_try_i[t];
        end

        fsc_thread_fsm #(
            .AW(AW), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)
        ) u_fsm (
            .clk       (clk),
            .rst       (rst),
            .ev_i      (ev),
            .stalled_i (any_next | ctx_switch_i),
            .cmt_tgt_i (cmt_target_i[t*AW +: AW]),
            .dec_tgt_i (dec_target_i[t*AW +: AW]),
            .st_q      (st),
            .pc_q      (pc_o[t*AW +: AW]),
            .npc_q     (npc_o[t*AW +: AW])
        );

        assign status_o[t*ST_W +: ST_W] = st;
    end

    fsc_activity #(.NT(NT)) u_act (
        .st_flat_i (status_o),
        .active_o  (stage_active_o)
    );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int NT = 2,
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [NT*4-1:0]  stall_set_i,
    input logic [NT*4-1:0]  stall_clr_i,
    input logic [NT*4-1:0]  stall_bits,
    input logic [NT-1:0]    cmt_squash_i,
    input logic [NT*AW-1:0] cmt_target_i,
    input logic [NT-1:0]    rob_unwind_i,
    input logic [NT-1:0]    dec_squash_i,
    input logic [NT-1:0]    line_ret_i,
    input logic [NT*4-1:0]  status_o,
    input logic [NT*AW-1:0] pc_o,
    input logic             stage_active_o
);
    for (genvar b = 0; b < NT*4; b++) begin : g_bit
        p_clear_needs_set_r2: assert property (@(posedge clk) disable iff (rst)
            stall_clr_i[b] |-> (stall_bits[b] && !stall_set_i[b]));
    end

    for (genvar t = 0; t < NT; t++) begin : g_t
        p_commit_wins_r3: assert property (@(posedge clk) disable iff (rst)
            cmt_squash_i[t] |=> (status_o[t*4 +: 4] == 4'd2 &&
                                 pc_o[t*AW +: AW] == $past(cmt_target_i[t*AW +: AW])));

        p_unwind_holds_r4: assert property (@(posedge clk) disable iff (rst)
            (rob_unwind_i[t] && !cmt_squash_i[t]) |=>
                (status_o[t*4 +: 4] == 4'd2 && $stable(pc_o[t*AW +: AW])));

        p_wait_kept_r6: assert property (@(posedge clk) disable iff (rst)
            (status_o[t*4 +: 4] == 4'd3 && !cmt_squash_i[t] && !rob_unwind_i[t] &&
             !dec_squash_i[t] && !line_ret_i[t]) |=> (status_o[t*4 +: 4] == 4'd3));

        p_ready_from_wait_r9: assert property (@(posedge clk) disable iff (rst)
            (status_o[t*4 +: 4] == 4'd4 && $past(status_o[t*4 +: 4]) != 4'd4) |->
                ($past(status_o[t*4 +: 4]) == 4'd3));
    end

    p_squash_makes_active_r11: assert property (@(posedge clk) disable iff (rst)
        (|cmt_squash_i) |=> stage_active_o);
endmodule

bind fetch_status_ctrl fsc_checker #(.NT(NT), .AW(AW)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .stall_set_i    (stall_set_i),
    .stall_clr_i    (stall_clr_i),
    .stall_bits     (stall_flat),
    .cmt_squash_i   (cmt_squash_i),
    .cmt_target_i   (cmt_target_i),
    .rob_unwind_i   (rob_unwind_i),
    .dec_squash_i   (dec_squash_i),
    .line_ret_i     (line_ret_i),
    .status_o       (status_o),
    .pc_o           (pc_o),
    .stage_active_o (stage_active_o)
);

// File: tb/sim_fetch_status_ctrl.sv
module sim_fetch_status_ctrl;
    localparam int CLK_NS = 10;
    localparam int NT = 2;
    localparam int AW = 32;
    localparam logic [31:0] RST_PC = 32'h0000_1000;

    localparam logic [3:0] S_RUN = 4'd0, S_BLK = 4'd1, S_SQ = 4'd2,
                           S_WAIT = 4'd3, S_RDY = 4'd4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NT*4-1:0]  stall_set, stall_clr;
    logic             ctx;
    logic [NT-1:0]    cmt_sq, rob, dec_sq, miss, line, ftry;
    logic [NT*AW-1:0] cmt_tgt, dec_tgt;
    logic [NT*4-1:0]  status;
    logic [NT*AW-1:0] pc, npc;
    logic [NT-1:0]    stalled;
    logic             active;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    fetch_status_ctrl #(.NT(NT), .AW(AW), .INST_BYTES(4), .RESET_PC(RST_PC)) u0 (
        .clk(clk), .rst(rst),
        .stall_set_i(stall_set), .stall_clr_i(stall_clr), .ctx_switch_i(ctx),
        .cmt_squash_i(cmt_sq), .cmt_target_i(cmt_tgt), .rob_unwind_i(rob),
        .dec_squash_i(dec_sq), .dec_target_i(dec_tgt), .miss_issue_i(miss),
        .line_ret_i(line), .fetch_try_i(ftry),
        .status_o(status), .pc_o(pc), .npc_o(npc),
        .stalled_o(stalled), .stage_active_o(active)
    );

    function automatic logic [3:0] st(int t);
        return status[t*4 +: 4];
    endfunction
    function automatic logic [31:0] pcv(int t);
        return pc[t*AW +: AW];
    endfunction
    function automatic logic [31:0] npcv(int t);
        return npc[t*AW +: AW];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        stall_set = '0; stall_clr = '0; ctx = 1'b0;
        cmt_sq = '0; rob = '0; dec_sq = '0; miss = '0; line = '0; ftry = '0;
    endtask

    // one clock edge, then drop all pulses; outputs are sampled after it
    task automatic cyc();
        @(negedge clk);
        clear_in();
    endtask

    task automatic t_reset();
        chk("R1 status t0", 32'(st(0)), S_RUN);
        chk("R1 status t1", 32'(st(1)), S_RUN);
        chk("R1 pc", pcv(0), RST_PC);
        chk("R1 npc", npcv(0), RST_PC + 4);
        chk("R1 stalled", 32'(stalled), 0);
        chk("R11 active at reset", 32'(active), 1);
    endtask

    task automatic t_stall();
        stall_set[0] = 1'b1; cyc();
        chk("R2 stalled after set", 32'(stalled[0]), 1);
        chk("R6 blocked", 32'(st(0)), S_BLK);
        chk("R12 other status", 32'(st(1)), S_RUN);
        chk("R12 other stalled", 32'(stalled[1]), 0);
        stall_set[1] = 1'b1; cyc();
        stall_clr[0] = 1'b1; cyc();
        chk("R2 rename still sticky", 32'(stalled[0]), 1);
        chk("R6 still blocked", 32'(st(0)), S_BLK);
        stall_clr[1] = 1'b1; cyc();
        chk("R2 all clear", 32'(stalled[0]), 0);
        chk("R7 back to running", 32'(st(0)), S_RUN);
    endtask

    task automatic t_ctx();
        ctx = 1'b1; cyc();
        chk("R6 ctx blocks t0", 32'(st(0)), S_BLK);
        chk("R6 ctx blocks t1", 32'(st(1)), S_BLK);
        chk("R11 inactive all blocked", 32'(active), 0);
        cyc();
        chk("R7 ctx released", 32'(st(1)), S_RUN);
        chk("R11 active again", 32'(active), 1);
    endtask

    task automatic t_commit();
        cmt_sq[0] = 1'b1; cmt_tgt[0 +: AW] = 32'h2000;
        dec_sq[0] = 1'b1; dec_tgt[0 +: AW] = 32'h3000;
        stall_set[3] = 1'b1;
        cyc();
        chk("R3 squash status", 32'(st(0)), S_SQ);
        chk("R3 commit target", pcv(0), 32'h2000);
        chk("R3 next addr", npcv(0), 32'h2004);
        chk("R2 commit stall set", 32'(stalled[0]), 1);
        cyc();
        chk("R6 stall after squash", 32'(st(0)), S_BLK);
        stall_clr[3] = 1'b1; cyc();
        chk("R7 run after commit stall", 32'(st(0)), S_RUN);
    endtask

    task automatic t_rob();
        for (int i = 0; i < 3; i++) begin
            rob[1] = 1'b1;
            if (i == 1) begin dec_sq[1] = 1'b1; dec_tgt[AW +: AW] = 32'h6000; end
            cyc();
            chk("R4 unwind holds squash", 32'(st(1)), S_SQ);
            chk("R4 addr unchanged", pcv(1), RST_PC);
        end
        cyc();
        chk("R7 unwind over", 32'(st(1)), S_RUN);
    endtask

    task automatic t_dec();
        dec_sq[0] = 1'b1; dec_tgt[0 +: AW] = 32'h4000; cyc();
        chk("R5 decode squash", 32'(st(0)), S_SQ);
        chk("R5 decode target", pcv(0), 32'h4000);
        chk("R5 decode next", npcv(0), 32'h4004);
        dec_sq[0] = 1'b1; dec_tgt[0 +: AW] = 32'h5000; cyc();
        chk("R5 second squash ignored", pcv(0), 32'h4000);
        chk("R7 squash done", 32'(st(0)), S_RUN);
    endtask

    task automatic t_cache();
        miss[0] = 1'b1; cyc();
        chk("R8 wait", 32'(st(0)), S_WAIT);
        stall_set[2] = 1'b1; cyc();
        chk("R6 wait kept under stall", 32'(st(0)), S_WAIT);
        line[0] = 1'b1; cyc();
        chk("R9 line while stalled", 32'(st(0)), S_BLK);
        stall_clr[2] = 1'b1; cyc();
        chk("R7 unstalled", 32'(st(0)), S_RUN);
        miss[0] = 1'b1; cyc();
        line[0] = 1'b1; cyc();
        chk("R9 line ready", 32'(st(0)), S_RDY);
        chk("R11 active ready", 32'(active), 1);
        ftry[0] = 1'b1; cyc();
        chk("R10 fetch attempt", 32'(st(0)), S_RUN);
        line[0] = 1'b1; cyc();
        chk("R9 stray line ignored", 32'(st(0)), S_RUN);
        miss[0] = 1'b1; cyc();
        line[0] = 1'b1; cyc();
        miss[0] = 1'b1; cyc();
        chk("R8 miss from ready", 32'(st(0)), S_WAIT);
        line[0] = 1'b1; cyc();
        ftry[0] = 1'b1; cyc();
        chk("R10 run again", 32'(st(0)), S_RUN);
    endtask

    task automatic t_squash_wait();
        miss[0] = 1'b1; cyc();
        cmt_sq[0] = 1'b1; cmt_tgt[0 +: AW] = 32'h7000; cyc();
        chk("R3 squash over wait", 32'(st(0)), S_SQ);
        chk("R3 target over wait", pcv(0), 32'h7000);
        cyc();
        line[0] = 1'b1; cyc();
        chk("R9 late line dropped", 32'(st(0)), S_RUN);
    endtask

    task automatic t_active();
        miss = 2'b11; cyc();
        chk("R11 both waiting", 32'(active), 0);
        line[1] = 1'b1; cyc();
        chk("R12 t1 ready", 32'(st(1)), S_RDY);
        chk("R12 t0 still waiting", 32'(st(0)), S_WAIT);
        chk("R11 one ready", 32'(active), 1);
        ftry[1] = 1'b1; line[0] = 1'b1; cyc();
        ftry[0] = 1'b1; cyc();
        chk("R10 t0 running", 32'(st(0)), S_RUN);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_in();
        cmt_tgt = '0; dec_tgt = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stall();
        t_ctx();
        t_commit();
        t_rob();
        t_dec();
        t_cache();
        t_squash_wait();
        t_active();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule